// File: doc/BRIEF.md
# Sequenced-Service Software Watchdog

A watchdog timer that raises a one-clock timeout pulse unless software services it often enough. Servicing takes two writes to the service register: first the arm key 0x55, then the fire key 0xAA. Any number of idle cycles may separate the two writes. The second key clears the count. A small control register holds three settings: an enable bit, a prescale bit that chooses the undivided clock or the clock divided by 2^PRE_LOG2, and a 2-bit period select.

At reset, the prescale bit takes its value from a clock-mode strap input. The written period select does not apply straight away: the counter keeps the old select until the next completed service. Software writes through a single-strobe port with a one-bit address. The control register reads back on `ctrl_o`. The reset controller uses `timeout_o`.

Top module: `wdog_seq_top`

## Requirements
- R1: On reset, `timeout_o` is 0 and `ctrl_o` reads enable=1 (bit0), period select=00 (bits 3:2), bits 7:4=0, and prescale (bit1) = inverse of `strap_clk_i`.
- R2: With prescale=0 and active select s, `timeout_o` pulses high for exactly one clock 2^(BASE_LOG2+STEP_LOG2*s) clocks after the last restart (512, 2048, 8192, 32768 by default), and the count restarts from zero on that pulse.
- R3: With prescale=1, the period of R2 is multiplied by 2^PRE_LOG2 (512 by default), measured from a completed service.
- R4: Writing 0x55 and then 0xAA to the service address (`wr_addr_i`=0) completes a service, even with any number of idle cycles in between. The count clears in the cycle 0xAA is accepted, so the next pulse follows one full period later.
- R5: A write of 0xAA with no pending 0x55 has no effect on the count.
- R6: Any service write other than 0x55 or 0xAA while 0x55 is pending clears the pending state, so a following 0xAA has no effect.
- R7: A new period select written to the control register does not change the running period until the next completed service, after which it takes effect.
- R8: While enable=0, the count is held at zero and no pulse occurs. After re-enabling, the first pulse comes one full period after the enabling write.
- R9: If a service completes in the same clock in which the count would expire, the service wins: no pulse, and a full period restarts.
- R10: A write to the control address (`wr_addr_i`=1) loads bit0 enable, bit1 prescale and bits 3:2 select from `wr_data_i`. Bits 7:4 are ignored and read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| strap_clk_i | input | 1 | Clock-mode strap, sampled at reset for the prescale bit |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | 0 = service register, 1 = control register |
| wr_data_i | input | 8 | Write data |
| ctrl_o | output | 8 | Control register readback |
| timeout_o | output | 1 | One-clock timeout pulse |

## Verification
The case that matters is a service completion that falls in the same clock as the count's expiry. The bench provokes it by timing the 0x55 write to be accepted one clock before the expiry edge and the 0xAA write to be accepted on the expiry edge itself. It then expects `timeout_o` to stay low in the cycle after that edge, and a full fresh period to pass before the next pulse. Deferred select, broken key pairs and disable are each judged by the exact cycle count to the next pulse.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [7:0] KEY_ARM  = 8'h55;
  localparam logic [7:0] KEY_FIRE = 8'hAA;

  typedef enum logic {
    ADDR_SVC  = 1'b0,
    ADDR_CTRL = 1'b1
  } wdog_addr_e;

  typedef struct packed {
    logic [1:0] sel;
    logic       pre;
    logic       en;
  } wdog_ctrl_t;
endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter int PRE_LOG2 = 9
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic pre_i,
  input  logic clr_i,
  output logic tick_o
);
  logic [PRE_LOG2-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (clr_i || !en_i || !pre_i) cnt_q <= '0;
    else                              cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = !pre_i || (&cnt_q);

  // R3: divided tick wraps the divider back to zero
  assert_div_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && pre_i && !clr_i && tick_o) |=> (cnt_q == '0));
  assert_div_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0));
endmodule

// File: rtl/wdog_keyseq.sv
module wdog_keyseq
  import wdog_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] data_i,
  output logic       svc_o
);
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     armed_q <= 1'b0;
    else if (wr_i)   armed_q <= (data_i == KEY_ARM);
  end

  assign svc_o = wr_i && armed_q && (data_i == KEY_FIRE);

  assert_fire_consumes_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc_o |=> !armed_q);
  assert_bad_key_disarms_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && data_i != KEY_ARM) |=> !armed_q);
  assert_fire_needs_arm_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && data_i == KEY_FIRE && !armed_q) |-> !svc_o);
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int BASE_LOG2 = 9,
  parameter int STEP_LOG2 = 2,
  parameter int SEL_W     = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             svc_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             timeout_o
);
  localparam int NSEL  = 1 << SEL_W;
  localparam int CNT_W = BASE_LOG2 + STEP_LOG2 * (NSEL - 1);

  logic [CNT_W-1:0] lim_tab [NSEL];
  logic [CNT_W-1:0] cnt_q, lim;
  logic [SEL_W-1:0] sel_act_q;
  logic             to_q;

  for (genvar g = 0; g < NSEL; g++) begin : g_lim
    assign lim_tab[g] = {CNT_W{1'b1}} >> (STEP_LOG2 * (NSEL - 1 - g));
  end

  assign lim = lim_tab[sel_act_q];

  // select held until a completed service
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sel_act_q <= '0;
    else if (svc_i) sel_act_q <= sel_i;
  end

  // service has priority over expiry in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      to_q  <= 1'b0;
    end else if (!en_i || svc_i) begin
      cnt_q <= '0;
      to_q  <= 1'b0;
    end else if (tick_i && cnt_q == lim) begin
      cnt_q <= '0;
      to_q  <= 1'b1;
    end else begin
      if (tick_i) cnt_q <= cnt_q + 1'b1;
      to_q <= 1'b0;
    end
  end

  assign timeout_o = to_q;

  assert_pulse_one_cycle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> !timeout_o);
  assert_count_in_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= lim);
  assert_disabled_holds_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0 && !timeout_o));
  assert_service_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc_i |=> (!timeout_o && cnt_q == '0));
  assert_select_deferred_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !svc_i |=> $stable(sel_act_q));
endmodule

// File: rtl/wdog_seq_top.sv
module wdog_seq_top
  import wdog_pkg::*;
#(
  parameter int BASE_LOG2 = 9,
  parameter int STEP_LOG2 = 2,
  parameter int PRE_LOG2  = 9
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       strap_clk_i,
  input  logic       wr_en_i,
  input  logic       wr_addr_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] ctrl_o,
  output logic       timeout_o
);
  wdog_ctrl_t ctrl_q;
  logic       svc_wr, ctrl_wr, svc, tick;
  logic       unused_hi;

  assign svc_wr  = wr_en_i && (wdog_addr_e'(wr_addr_i) == ADDR_SVC);
  assign ctrl_wr = wr_en_i && (wdog_addr_e'(wr_addr_i) == ADDR_CTRL);
  assign unused_hi = ^wr_data_i[7:4];

  // prescale reset value comes from the strap
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q.en  <= 1'b1;
      ctrl_q.pre <= ~strap_clk_i;
      ctrl_q.sel <= '0;
    end else if (ctrl_wr) begin
      ctrl_q <= wdog_ctrl_t'(wr_data_i[3:0]);
    end
  end

  assign ctrl_o = {4'b0000, ctrl_q};

  wdog_keyseq u_keys (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (svc_wr),
    .data_i (wr_data_i),
    .svc_o  (svc)
  );

  wdog_prescale #(.PRE_LOG2(PRE_LOG2)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (ctrl_q.en),
    .pre_i  (ctrl_q.pre),
    .clr_i  (svc),
    .tick_o (tick)
  );

  wdog_counter #(
    .BASE_LOG2 (BASE_LOG2),
    .STEP_LOG2 (STEP_LOG2),
    .SEL_W     (2)
  ) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (ctrl_q.en),
    .tick_i    (tick),
    .svc_i     (svc),
    .sel_i     (ctrl_q.sel),
    .timeout_o (timeout_o)
  );

  assert_ctrl_hi_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr |=> (ctrl_o[7:4] == 4'h0 && ctrl_o[3:0] == $past(wr_data_i[3:0])));
  assert_svc_keeps_ctrl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc_wr |=> $stable(ctrl_o));
endmodule

// File: tb/sim_wdog_seq_top.sv
module sim_wdog_seq_top;
  typedef struct packed {
    logic        pre;
    logic [1:0]  sel;
    logic [31:0] period;
  } vec_t;

  // prescale divider shortened to 2^4 for the bench run
  localparam vec_t VECS [5] = '{
    '{pre: 1'b0, sel: 2'd0, period: 32'd512},
    '{pre: 1'b0, sel: 2'd1, period: 32'd2048},
    '{pre: 1'b0, sel: 2'd2, period: 32'd8192},
    '{pre: 1'b0, sel: 2'd3, period: 32'd32768},
    '{pre: 1'b1, sel: 2'd0, period: 32'd8192}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strap = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_addr = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] ctrl;
  logic       timeout;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #5 clk = ~clk;

  wdog_seq_top #(.BASE_LOG2(9), .STEP_LOG2(2), .PRE_LOG2(4)) u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .strap_clk_i (strap),
    .wr_en_i     (wr_en),
    .wr_addr_i   (wr_addr),
    .wr_data_i   (wr_data),
    .ctrl_o      (ctrl),
    .timeout_o   (timeout)
  );

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=%0d cycles expected<190000", cyc);
      summary();
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic service();
    wr(1'b0, 8'h55);
    wr(1'b0, 8'hAA);
  endtask

  task automatic measure(input int limit, output int n);
    n = 0;
    while (n <= limit) begin
      @(negedge clk);
      n++;
      if (timeout) break;
    end
  endtask

  task automatic do_reset(input logic s);
    rst_n = 1'b0; strap = s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    int n;
    int seen;
    // R1 reset state for both strap values
    do_reset(1'b0);
    chk(timeout == 1'b0, "R1 timeout", timeout, 0);
    chk(ctrl == 8'h03, "R1 ctrl strap0", ctrl, 8'h03);
    do_reset(1'b1);
    chk(ctrl == 8'h01, "R1 ctrl strap1", ctrl, 8'h01);

    // R10 upper bits ignored
    wr(1'b1, 8'hF1);
    chk(ctrl == 8'h01, "R10 readback", ctrl, 8'h01);

    // R2 R3 period table
    foreach (VECS[i]) begin
      wr(1'b1, {4'h0, VECS[i].sel, VECS[i].pre, 1'b1});
      service();
      measure(VECS[i].period + 20, n);
      chk(n == int'(VECS[i].period), VECS[i].pre ? "R3 period" : "R2 period", n, VECS[i].period);
      @(negedge clk);
      chk(timeout == 1'b0, "R2 pulse width", timeout, 0);
      if (i == 0) begin
        measure(VECS[i].period + 20, n);
        chk(n == int'(VECS[i].period) - 1, "R2 restart", n, VECS[i].period - 1);
      end
    end

    wr(1'b1, 8'h01);
    // R5 lone fire key
    service();
    wr(1'b0, 8'hAA);
    measure(600, n);
    chk(n == 511, "R5 lone 0xAA", n, 511);

    // R6 broken pair
    service();
    wr(1'b0, 8'h55);
    wr(1'b0, 8'h11);
    wr(1'b0, 8'hAA);
    measure(600, n);
    chk(n == 509, "R6 broken pair", n, 509);

    // R4 gap between keys
    service();
    wr(1'b0, 8'h55);
    repeat (100) @(negedge clk);
    chk(timeout == 1'b0, "R4 gap no pulse", timeout, 0);
    wr(1'b0, 8'hAA);
    measure(600, n);
    chk(n == 512, "R4 gap service", n, 512);

    // R7 deferred select
    service();
    wr(1'b1, 8'h05);
    measure(600, n);
    chk(n == 511, "R7 old period kept", n, 511);
    service();
    measure(2100, n);
    chk(n == 2048, "R7 new period", n, 2048);
    chk(ctrl == 8'h05, "R10 select readback", ctrl, 8'h05);
    wr(1'b1, 8'h01);
    service();

    // R9 service on the expiry edge
    service();
    seen = 0;
    repeat (510) begin
      @(negedge clk);
      if (timeout) seen++;
    end
    wr(1'b0, 8'h55);
    if (timeout) seen++;
    wr(1'b0, 8'hAA);
    chk(timeout == 1'b0, "R9 collision no pulse", timeout, 0);
    chk(seen == 0, "R9 no early pulse", seen, 0);
    measure(600, n);
    chk(n == 512, "R9 full restart", n, 512);

    // R8 disable
    wr(1'b1, 8'h00);
    chk(ctrl == 8'h00, "R8 ctrl off", ctrl, 0);
    seen = 0;
    repeat (1000) begin
      @(negedge clk);
      if (timeout) seen++;
    end
    chk(seen == 0, "R8 no pulse when off", seen, 0);
    wr(1'b1, 8'h01);
    measure(600, n);
    chk(n == 512, "R8 re-enable period", n, 512);

    summary();
  end
endmodule